// File: doc/BRIEF.md
# Decode-Stage Hazard Controller

This block is the purely combinational hazard controller of a five-stage, in-order RV32I pipeline in which branches and jumps are decided in the decode stage, with operands forwarded into that stage. Each cycle it compares the two decode-stage source registers with the destinations of the instructions now in execute and in memory. From that comparison it decides whether the front end must freeze, or whether the instruction fetched just behind a taken control transfer must be discarded.

Decoding a branch in the decode stage has a cost. A branch or jump in decode cannot use a result that is still being computed in execute, and it cannot use load data that is still in flight in the memory stage. An ordinary instruction in decode stalls only behind a load in execute. A register-indirect jump is marked as a control transfer and uses its base register, so it waits until that base value can be forwarded.

When the controller stalls, it holds the program counter and the fetch/decode register, and it puts a bubble into the decode/execute register. When a taken transfer is not stalled, it replaces the fetch/decode register with a NOP, which costs one cycle. The block has no state. Every output follows the inputs of the current cycle.

Top module: `hazard_ctrl`

## Requirements
- R1: The stall outputs are raised when the decode stage holds a branch or jump, or the execute stage holds a load, and the execute destination is nonzero and equals a source register that decode uses.
- R2: The stall outputs are raised when the decode stage holds a branch or jump, the memory stage holds a load, and the memory destination is nonzero and equals a source register that decode uses.
- R3: A destination register of 0 (x0), in either stage, never causes a stall.
- R4: A source register whose use flag is 0 never causes a stall, even if its number matches a destination.
- R5: A stall raises `pc_hold`, `fd_hold` and `dx_bubble` together, and these three outputs are always equal.
- R6: When `xfer_taken` is 1 and there is no stall, `fd_flush` is 1 and the three stall outputs are 0. This discards exactly one fetched instruction.
- R7: A stall takes priority: while stalled, `fd_flush` is 0 whatever the value of `xfer_taken`.
- R8: In these cases there is no stall: a non-load in the memory stage, a load in the memory stage when decode holds no branch or jump, and a non-load in execute when decode holds no branch or jump.
- R9: With no matching hazard and `xfer_taken` at 0, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs1 | input | REG_W | Decode-stage first source register number |
| dec_rs2 | input | REG_W | Decode-stage second source register number |
| dec_rs1_used | input | 1 | The decode instruction reads its first source |
| dec_rs2_used | input | 1 | The decode instruction reads its second source |
| dec_xfer | input | 1 | The decode instruction is a branch or a jump |
| ex_rd | input | REG_W | Execute-stage destination register |
| ex_load | input | 1 | The execute-stage instruction is a load |
| mem_rd | input | REG_W | Memory-stage destination register |
| mem_load | input | 1 | The memory-stage instruction is a load |
| xfer_taken | input | 1 | A branch or jump was taken this cycle |
| pc_hold | output | 1 | Keep the program counter unchanged |
| fd_hold | output | 1 | Keep the fetch/decode register unchanged |
| fd_flush | output | 1 | Load a NOP into the fetch/decode register |
| dx_bubble | output | 1 | Load a bubble (all enables cleared) into the decode/execute register |

## Verification
The assertions check, in every settled cycle, that the three stall outputs agree with one another, that a flush never appears together with a stall, and that an unstalled taken transfer always flushes. They also check that a stall never appears when both destinations are x0 or when neither source is used. Only the bench's scenarios can show that the hazards are detected in the right cases. These are the split between execute and memory, the load and non-load combinations, matches on only the second source, and the cases where a match must not stall. The bench checks these against its own model of the stall rules, using both directed cases and biased random register numbers.

// File: rtl/hazard_ctrl.sv
module hazard_ctrl #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] dec_rs1,
  input  logic [REG_W-1:0] dec_rs2,
  input  logic             dec_rs1_used,
  input  logic             dec_rs2_used,
  input  logic             dec_xfer,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_load,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_load,
  input  logic             xfer_taken,
  output logic             pc_hold,
  output logic             fd_hold,
  output logic             fd_flush,
  output logic             dx_bubble
);

  localparam int NSRC = 2;

  logic [REG_W-1:0] src [NSRC];
  logic [NSRC-1:0]  use_v;
  logic [NSRC-1:0]  hit_ex;
  logic [NSRC-1:0]  hit_mem;

  assign src[0]   = dec_rs1;
  assign src[1]   = dec_rs2;
  assign use_v    = {dec_rs2_used, dec_rs1_used};

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign hit_ex[i]  = use_v[i] && (ex_rd  != '0) && (src[i] == ex_rd);
    assign hit_mem[i] = use_v[i] && (mem_rd != '0) && (src[i] == mem_rd);
  end

  logic stall_ex, stall_mem, stall;

  assign stall_ex  = (dec_xfer || ex_load) && (|hit_ex);
  assign stall_mem = dec_xfer && mem_load && (|hit_mem);
  assign stall     = stall_ex || stall_mem;

  assign pc_hold   = stall;
  assign fd_hold   = stall;
  assign dx_bubble = stall;
  assign fd_flush  = xfer_taken && !stall;

endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk #(
  parameter int REG_W = 5
) (
  input logic [REG_W-1:0] dec_rs1,
  input logic [REG_W-1:0] dec_rs2,
  input logic             dec_rs1_used,
  input logic             dec_rs2_used,
  input logic             dec_xfer,
  input logic [REG_W-1:0] ex_rd,
  input logic             ex_load,
  input logic [REG_W-1:0] mem_rd,
  input logic             mem_load,
  input logic             xfer_taken,
  input logic             pc_hold,
  input logic             fd_hold,
  input logic             fd_flush,
  input logic             dx_bubble
);

  logic known;
  assign known = !$isunknown({dec_rs1, dec_rs2, dec_rs1_used, dec_rs2_used, dec_xfer,
                              ex_rd, ex_load, mem_rd, mem_load, xfer_taken,
                              pc_hold, fd_hold, fd_flush, dx_bubble});

  always_comb begin
    if (known) begin
      p_holds_agree_r5: assert (pc_hold == fd_hold && fd_hold == dx_bubble);
      p_stall_over_flush_r7: assert (!(fd_flush && pc_hold));
      p_taken_flushes_r6: assert (!(xfer_taken && !pc_hold) || fd_flush);
      p_x0_quiet_r3: assert (!(ex_rd == '0 && mem_rd == '0) || !pc_hold);
      p_unused_quiet_r4: assert (dec_rs1_used || dec_rs2_used || !pc_hold);
      p_idle_quiet_r9: assert (!(!dec_xfer && !ex_load && !xfer_taken)
                               || (!pc_hold && !fd_flush));
    end
  end

endmodule

bind hazard_ctrl hazard_ctrl_chk #(.REG_W(REG_W)) u_chk (
  .dec_rs1(dec_rs1), .dec_rs2(dec_rs2),
  .dec_rs1_used(dec_rs1_used), .dec_rs2_used(dec_rs2_used),
  .dec_xfer(dec_xfer), .ex_rd(ex_rd), .ex_load(ex_load),
  .mem_rd(mem_rd), .mem_load(mem_load), .xfer_taken(xfer_taken),
  .pc_hold(pc_hold), .fd_hold(fd_hold), .fd_flush(fd_flush), .dx_bubble(dx_bubble)
);

// File: tb/sim_hazard_ctrl.sv
module sim_hazard_ctrl;
  localparam int W = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] rs1, rs2, exrd, memrd;
  logic u1, u2, xf, exl, meml, tk;
  logic pch, fdh, fdf, dxb;

  int n_chk = 0;
  int n_bad = 0;

  hazard_ctrl #(.REG_W(W)) u0 (
    .dec_rs1(rs1), .dec_rs2(rs2), .dec_rs1_used(u1), .dec_rs2_used(u2),
    .dec_xfer(xf), .ex_rd(exrd), .ex_load(exl), .mem_rd(memrd), .mem_load(meml),
    .xfer_taken(tk), .pc_hold(pch), .fd_hold(fdh), .fd_flush(fdf), .dx_bubble(dxb)
  );

  function automatic logic m_hit(logic [W-1:0] r, logic u, logic [W-1:0] d);
    return u && d != 0 && r == d;
  endfunction

  function automatic logic m_stall_ex();
    return (xf || exl) && (m_hit(rs1, u1, exrd) || m_hit(rs2, u2, exrd));
  endfunction

  function automatic logic m_stall_mem();
    return xf && meml && (m_hit(rs1, u1, memrd) || m_hit(rs2, u2, memrd));
  endfunction

  // expected {pc_hold, fd_hold, fd_flush, dx_bubble}
  function automatic logic [3:0] m_out();
    logic s;
    s = m_stall_ex() || m_stall_mem();
    return {s, s, tk && !s, s};
  endfunction

  task automatic put(input logic [W-1:0] a, input logic [W-1:0] b, input logic ua,
                     input logic ub, input logic x, input logic [W-1:0] er,
                     input logic el, input logic [W-1:0] mr, input logic ml,
                     input logic t);
    @(negedge clk);
    rs1 = a; rs2 = b; u1 = ua; u2 = ub; xf = x;
    exrd = er; exl = el; memrd = mr; meml = ml; tk = t;
    #2;
  endtask

  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {pch, fdh, fdf, dxb};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: outputs %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    // idle state after start-up: all outputs low (R9)
    put(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);           chk("R9 idle", 4'b0000);
    put(3, 4, 1, 1, 0, 7, 0, 8, 0, 0);           chk("R9 no match", 4'b0000);
    // R1: load in execute, ordinary decode, match on rs1 and on rs2
    put(6, 2, 1, 1, 0, 6, 1, 0, 0, 0);           chk("R1 load-use rs1", 4'b1101);
    put(1, 9, 1, 1, 0, 9, 1, 0, 0, 0);           chk("R1 load-use rs2", 4'b1101);
    // R1: branch in decode behind an ALU result in execute
    put(5, 0, 1, 1, 1, 5, 0, 0, 0, 0);           chk("R1 xfer behind alu", 4'b1101);
    // R2: branch behind a load in memory
    put(11, 12, 1, 1, 1, 3, 0, 12, 1, 0);        chk("R2 xfer behind mem load", 4'b1101);
    // R8: cases that must not stall
    put(11, 12, 1, 1, 1, 3, 0, 12, 0, 0);        chk("R8 mem non-load", 4'b0000);
    put(11, 12, 1, 1, 0, 3, 0, 12, 1, 0);        chk("R8 mem load plain decode", 4'b0000);
    put(5, 6, 1, 1, 0, 5, 0, 0, 0, 0);           chk("R8 ex alu plain decode", 4'b0000);
    // R3: x0 destinations
    put(0, 0, 1, 1, 1, 0, 1, 0, 1, 0);           chk("R3 x0 both", 4'b0000);
    // R4: match on unused sources (e.g. I-type rs2 field, jal)
    put(1, 7, 1, 0, 0, 7, 1, 0, 0, 0);           chk("R4 unused rs2", 4'b0000);
    put(7, 7, 0, 0, 1, 7, 1, 7, 1, 1);           chk("R4 no sources used", 4'b0010);
    // R6: taken transfer unstalled: one flush
    put(2, 3, 1, 1, 1, 8, 1, 9, 1, 1);           chk("R6 taken flush", 4'b0010);
    put(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);           chk("R6 flush one cycle", 4'b0000);
    // R7: register-indirect jump on unready base: stall wins over taken
    put(10, 0, 1, 0, 1, 10, 1, 0, 0, 1);         chk("R7 stall beats flush ex", 4'b1101);
    put(10, 0, 1, 0, 1, 4, 0, 10, 1, 1);         chk("R7 stall beats flush mem", 4'b1101);
    // R5 across random mix, registers biased to small numbers
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] e;
      string tag;
      put(W'($urandom_range(0, 3)), W'($urandom_range(0, 3)), 1'($urandom),
          1'($urandom), 1'($urandom), W'($urandom_range(0, 3)), 1'($urandom),
          W'($urandom_range(0, 3)), 1'($urandom), 1'($urandom));
      e = m_out();
      if (m_stall_ex())       tag = "R1 random";
      else if (m_stall_mem()) tag = "R2 random";
      else if (tk)            tag = "R6 random";
      else                    tag = "R9 random";
      chk(tag, e);
      if (e[3] && tk) chk("R7 random", e);
      n_chk++;
      if (!(pch == fdh && fdh == dxb)) begin
        n_bad++;
        $display("FAIL R5: holds %b%b%b expected equal", pch, fdh, dxb);
      end
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule